// File: doc/BRIEF.md
# MSI Vector Allocation Table Controller

This block keeps a small associative table that ties a PCI configuration-space address to a contiguous block of message-signalled interrupt numbers. Software-side agents send it commands one at a time over a valid/ready port. A change command either enables vectors or releases them, depending on whether the requested count is zero. A query command translates a device-relative vector number into a system interrupt number.

On enable, the block scans the table one entry per cycle, from the lowest index. The scan stops at the first match or at the first empty slot. If the device is new, the block asks an external interrupt allocator for a base number through a request/grant handshake, and it writes the entry only after a grant. It then emits, one per cycle, the message addresses the device must be programmed with (message data is always zero). Finally it pulses a done strobe with a status, the granted count, an incremented sequence number and the interrupt type. Entries are never removed: a release reports success but leaves the entry in place.

Top module: `msi_vec_table`

## Requirements
- R1: `cmd_ready` is high only while no command is in progress. Each command ends with `rsp_done` high for exactly one cycle. The response fields are valid in that cycle and stay unchanged until the next command is accepted.
- R2: For a change command, `cmd_func` 1 or 3 selects plain MSI and reports `rsp_type` 1. `cmd_func` 4 selects MSI-X and reports `rsp_type` 2. Any other code reports status 8'hFD with count 0 and type 0, requests no allocation and changes no entry.
- R3: Enabling an unknown device when an empty slot exists raises `alloc_req` with `alloc_count` equal to the request. After `alloc_grant`, the block stores the entry and reports status 8'h00, count equal to the request, sequence equal to `cmd_seq`+1, and the type.
- R4: `alloc_req` stays high until `alloc_grant` or `alloc_fail`. A failure reports status 8'hFF and leaves the table unchanged, so a later query of that address reports 8'hFF.
- R5: When every slot is occupied, enabling a new address reports 8'hFF without raising `alloc_req`.
- R6: Enabling a known device with the same count succeeds without an allocation and reuses its slot. Enabling it with a different nonzero count reports 8'hFF.
- R7: A change command with count 0 on a known device reports 8'h00 with count 0 and keeps the entry, so queries still succeed. On an unknown device it reports 8'hFF.
- R8: A query on a known device reports 8'h00, `rsp_irq` equal to the stored base plus `cmd_vec`, and `rsp_edge` 1. On an unknown device it reports 8'hFF with `rsp_edge` 0.
- R9: A successful enable drives `msg_valid` in consecutive cycles before `rsp_done`. For MSI it sends one address, `WIN_BASE | slot<<16`. For MSI-X it sends `count` addresses, `WIN_BASE | slot<<16 | i<<2`, for i rising from 0.
- R10: New devices take slots in the order they are first granted, starting at slot 0, because the scan stops at the lowest empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_query | input | 1 | 1 = query, 0 = change |
| cmd_func | input | 4 | Change function code |
| cmd_key | input | KEY_W | Configuration-space address of the device |
| cmd_count | input | CNT_W | Requested vector count, 0 = release |
| cmd_seq | input | SEQ_W | Sequence number to echo plus one |
| cmd_vec | input | IRQ_W | Device-relative vector for a query |
| alloc_req | output | 1 | Interrupt block request |
| alloc_count | output | CNT_W | Size of the requested block |
| alloc_grant | input | 1 | Allocation succeeded |
| alloc_fail | input | 1 | Allocation refused |
| alloc_base | input | IRQ_W | First interrupt of the granted block |
| msg_valid | output | 1 | Message address valid |
| msg_addr | output | ADDR_W | Message address for the device |
| rsp_done | output | 1 | Response strobe |
| rsp_status | output | 8 | 8'h00 ok, 8'hFF hardware error, 8'hFD parameter error |
| rsp_count | output | CNT_W | Granted vector count |
| rsp_seq | output | SEQ_W | Sequence number plus one |
| rsp_type | output | 2 | 0 none, 1 MSI, 2 MSI-X |
| rsp_irq | output | IRQ_W | Interrupt number from a query |
| rsp_edge | output | 1 | 1 = edge-triggered, set on a successful query |

## Verification
The bench builds the block with `ENTRIES` = 4 and `CNT_W` = 4 and keeps the default window base. With only four slots, a handful of commands fills the table, so the full-table refusal and scans that run to the last slot are reachable. Every slot is occupied and queried in turn. The narrow count lets one MSI-X enable use the largest count, 15, and check every one of its message addresses. It also sweeps every invalid function code. The bench supplies the allocator, grants base 64×(slot+1) and fails one request on purpose.

// File: rtl/msi_tab_pkg.sv
// Shared types and codes for the MSI vector allocation table.
// Assumes nothing beyond being compiled before the modules that import it.
package msi_tab_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_ALLOC,
        ST_EMIT,
        ST_DONE
    } msi_state_t;

    localparam logic [7:0] STAT_OK        = 8'h00;
    localparam logic [7:0] STAT_HW_ERR    = 8'hFF;
    localparam logic [7:0] STAT_PARAM_ERR = 8'hFD;

    localparam logic [1:0] TYPE_NONE = 2'd0;
    localparam logic [1:0] TYPE_MSI  = 2'd1;
    localparam logic [1:0] TYPE_MSIX = 2'd2;

    // Map a change function code to the interrupt type it selects.
    function automatic logic [1:0] decode_func(input logic [3:0] func);
        case (func)
            4'd1, 4'd3: decode_func = TYPE_MSI;
            4'd4:       decode_func = TYPE_MSIX;
            default:    decode_func = TYPE_NONE;
        endcase
    endfunction
endpackage

// File: rtl/msi_tab_store.sv
// Entry storage: key, interrupt base and vector count for each slot.
// Assumes one write port and one combinational read port.
// Only the count is reset; a zero count marks the slot as empty.
module msi_tab_store #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5,
    parameter int KEY_W   = 32,
    parameter int IRQ_W   = 32,
    parameter int CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [IRQ_W-1:0] wr_base,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key,
    output logic [IRQ_W-1:0] rd_base,
    output logic [CNT_W-1:0] rd_cnt
);
    logic [KEY_W-1:0] key_q  [ENTRIES];
    logic [IRQ_W-1:0] base_q [ENTRIES];
    logic [CNT_W-1:0] cnt_q  [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Write one slot; reset clears only its occupancy count.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                key_q[g]  <= wr_key;
                base_q[g] <= wr_base;
                cnt_q[g]  <= wr_cnt;
            end
        end
    end

    // Read port used by the scan.
    assign rd_key  = key_q[rd_idx];
    assign rd_base = base_q[rd_idx];
    assign rd_cnt  = cnt_q[rd_idx];
endmodule

// File: rtl/msi_tab_match.sv
// Compares one table entry against the search key.
// Assumes that a zero count means the slot was never filled.
module msi_tab_match #(
    parameter int KEY_W = 32,
    parameter int CNT_W = 6
) (
    input  logic [KEY_W-1:0] ent_key,
    input  logic [CNT_W-1:0] ent_cnt,
    input  logic [KEY_W-1:0] key,
    output logic             slot_empty,
    output logic             slot_hit
);
    // Classify the entry as empty, matching or neither.
    always_comb begin
        slot_empty = (ent_cnt == '0);
        slot_hit   = !slot_empty && (ent_key == key);
    end
endmodule

// File: rtl/msi_msg_addr.sv
// Forms the message address for a slot and a vector.
// Assumes WIN_BASE has zeros in the bits that slot and vector occupy.
module msi_msg_addr #(
    parameter int                ADDR_W   = 32,
    parameter int                IDX_W    = 5,
    parameter int                CNT_W    = 6,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h9000_0000
) (
    input  logic [IDX_W-1:0]  slot,
    input  logic [CNT_W-1:0]  vec,
    input  logic              per_vec,
    output logic [ADDR_W-1:0] addr
);
    localparam int SLOT_SHIFT = 16;
    localparam int VEC_SHIFT  = 2;

    // Window base, slot page and (for MSI-X) the vector word.
    always_comb begin
        addr = WIN_BASE | (ADDR_W'(slot) << SLOT_SHIFT);
        if (per_vec) begin
            addr = addr | (ADDR_W'(vec) << VEC_SHIFT);
        end
    end
endmodule

// File: rtl/msi_vec_table.sv
// MSI vector allocation table controller (top).
// Serves one change or query command at a time. The table scan takes one
// entry per cycle and stops at the first hit or empty slot. A new entry is
// written only after the external allocator grants a base. Assumes
// ENTRIES >= 2 and that the allocator answers every request eventually.
module msi_vec_table #(
    parameter int                ENTRIES  = 32,
    parameter int                KEY_W    = 32,
    parameter int                IRQ_W    = 32,
    parameter int                CNT_W    = 6,
    parameter int                SEQ_W    = 32,
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h9000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_query,
    input  logic [3:0]        cmd_func,
    input  logic [KEY_W-1:0]  cmd_key,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [SEQ_W-1:0]  cmd_seq,
    input  logic [IRQ_W-1:0]  cmd_vec,
    output logic              alloc_req,
    output logic [CNT_W-1:0]  alloc_count,
    input  logic              alloc_grant,
    input  logic              alloc_fail,
    input  logic [IRQ_W-1:0]  alloc_base,
    output logic              msg_valid,
    output logic [ADDR_W-1:0] msg_addr,
    output logic              rsp_done,
    output logic [7:0]        rsp_status,
    output logic [CNT_W-1:0]  rsp_count,
    output logic [SEQ_W-1:0]  rsp_seq,
    output logic [1:0]        rsp_type,
    output logic [IRQ_W-1:0]  rsp_irq,
    output logic              rsp_edge
);
    import msi_tab_pkg::*;

    localparam int               IDX_W    = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    msi_state_t       state;
    logic [KEY_W-1:0] key_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SEQ_W-1:0] seq_q;
    logic [IRQ_W-1:0] vec_q;
    logic             query_q;
    logic [1:0]       type_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] slot_q;
    logic [CNT_W-1:0] emit_q;

    logic [KEY_W-1:0] rd_key;
    logic [IRQ_W-1:0] rd_base;
    logic [CNT_W-1:0] rd_cnt;
    logic             slot_empty;
    logic             slot_hit;
    logic             tbl_wr;
    logic [1:0]       dec_type;
    logic [CNT_W-1:0] emit_last;

    msi_tab_store #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .KEY_W(KEY_W),
        .IRQ_W(IRQ_W), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr), .wr_idx(slot_q), .wr_key(key_q),
        .wr_base(alloc_base), .wr_cnt(cnt_q),
        .rd_idx(idx_q), .rd_key(rd_key), .rd_base(rd_base), .rd_cnt(rd_cnt)
    );

    msi_tab_match #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_match (
        .ent_key(rd_key), .ent_cnt(rd_cnt), .key(key_q),
        .slot_empty(slot_empty), .slot_hit(slot_hit)
    );

    msi_msg_addr #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .WIN_BASE(WIN_BASE)
    ) u_addr (
        .slot(slot_q), .vec(emit_q), .per_vec(type_q == TYPE_MSIX),
        .addr(msg_addr)
    );

    // Handshake, allocator and emission strobes follow the state.
    always_comb begin
        cmd_ready   = (state == ST_IDLE);
        alloc_req   = (state == ST_ALLOC);
        alloc_count = cnt_q;
        msg_valid   = (state == ST_EMIT);
        tbl_wr      = (state == ST_ALLOC) && alloc_grant;
        dec_type    = decode_func(cmd_func);
        emit_last   = (type_q == TYPE_MSIX) ? cnt_q - CNT_W'(1) : '0;
    end

    // Command sequencing: accept, scan, allocate, emit, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            key_q      <= '0;
            cnt_q      <= '0;
            seq_q      <= '0;
            vec_q      <= '0;
            query_q    <= 1'b0;
            type_q     <= TYPE_NONE;
            idx_q      <= '0;
            slot_q     <= '0;
            emit_q     <= '0;
            rsp_done   <= 1'b0;
            rsp_status <= STAT_OK;
            rsp_count  <= '0;
            rsp_seq    <= '0;
            rsp_type   <= TYPE_NONE;
            rsp_irq    <= '0;
            rsp_edge   <= 1'b0;
        end else begin
            rsp_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        key_q      <= cmd_key;
                        cnt_q      <= cmd_count;
                        seq_q      <= cmd_seq;
                        vec_q      <= cmd_vec;
                        query_q    <= cmd_query;
                        type_q     <= cmd_query ? TYPE_NONE : dec_type;
                        idx_q      <= '0;
                        emit_q     <= '0;
                        rsp_status <= STAT_OK;
                        rsp_count  <= '0;
                        rsp_seq    <= '0;
                        rsp_type   <= TYPE_NONE;
                        rsp_irq    <= '0;
                        rsp_edge   <= 1'b0;
                        if (!cmd_query && dec_type == TYPE_NONE) begin
                            rsp_status <= STAT_PARAM_ERR;
                            rsp_done   <= 1'b1;
                            state      <= ST_DONE;
                        end else begin
                            state <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (slot_hit || slot_empty || idx_q == LAST_IDX) begin
                        slot_q <= idx_q;
                        if (query_q) begin
                            rsp_status <= slot_hit ? STAT_OK : STAT_HW_ERR;
                            rsp_irq    <= slot_hit ? rd_base + vec_q : '0;
                            rsp_edge   <= slot_hit;
                            rsp_done   <= 1'b1;
                            state      <= ST_DONE;
                        end else if (cnt_q == '0) begin
                            rsp_status <= slot_hit ? STAT_OK : STAT_HW_ERR;
                            rsp_done   <= 1'b1;
                            state      <= ST_DONE;
                        end else if (slot_hit && rd_cnt == cnt_q) begin
                            state <= ST_EMIT;
                        end else if (slot_empty) begin
                            state <= ST_ALLOC;
                        end else begin
                            rsp_status <= STAT_HW_ERR;
                            rsp_done   <= 1'b1;
                            state      <= ST_DONE;
                        end
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_ALLOC: begin
                    if (alloc_grant) begin
                        state <= ST_EMIT;
                    end else if (alloc_fail) begin
                        rsp_status <= STAT_HW_ERR;
                        rsp_done   <= 1'b1;
                        state      <= ST_DONE;
                    end
                end
                ST_EMIT: begin
                    emit_q <= emit_q + CNT_W'(1);
                    if (emit_q == emit_last) begin
                        rsp_status <= STAT_OK;
                        rsp_count  <= cnt_q;
                        rsp_seq    <= seq_q + SEQ_W'(1);
                        rsp_type   <= type_q;
                        rsp_done   <= 1'b1;
                        state      <= ST_DONE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/msi_vec_table_chk.sv
// Protocol checker for msi_vec_table, attached by bind.
// Assumes it sees the top-level ports only.
module msi_vec_table_chk #(
    parameter int CNT_W = 6,
    parameter int SEQ_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [SEQ_W-1:0] cmd_seq,
    input logic             alloc_req,
    input logic             alloc_grant,
    input logic             alloc_fail,
    input logic             msg_valid,
    input logic             rsp_done,
    input logic [7:0]       rsp_status,
    input logic [CNT_W-1:0] rsp_count,
    input logic [SEQ_W-1:0] rsp_seq,
    input logic [1:0]       rsp_type,
    input logic             rsp_edge
);
    logic [SEQ_W-1:0] seq_cap;

    // Remember the sequence number of the command in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_cap <= '0;
        else if (cmd_valid && cmd_ready) seq_cap <= cmd_seq;
    end

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!alloc_req && !msg_valid && !rsp_done));

    assert_param_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_status == 8'hFD) |-> (rsp_type == 2'd0 && rsp_count == '0));

    assert_seq_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_type != 2'd0) |-> (rsp_status == 8'h00 && rsp_seq == seq_cap + SEQ_W'(1)));

    assert_alloc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_grant && !alloc_fail) |=> alloc_req);

    assert_edge_only_query_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_edge) |-> (rsp_status == 8'h00 && rsp_type == 2'd0));

    assert_emit_contig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> (msg_valid || rsp_done));
endmodule

bind msi_vec_table msi_vec_table_chk #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_seq(cmd_seq), .alloc_req(alloc_req), .alloc_grant(alloc_grant),
    .alloc_fail(alloc_fail), .msg_valid(msg_valid), .rsp_done(rsp_done),
    .rsp_status(rsp_status), .rsp_count(rsp_count), .rsp_seq(rsp_seq),
    .rsp_type(rsp_type), .rsp_edge(rsp_edge)
);

// File: tb/sim_msi_vec_table.sv
// Self-checking bench: four-slot table, bench-side allocator model.
module sim_msi_vec_table;
    localparam int          CLK_PERIOD = 10;
    localparam int          ENTRIES    = 4;
    localparam int          CNT_W      = 4;
    localparam logic [31:0] WIN        = 32'h9000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_query = 1'b0;
    logic [3:0]  cmd_func = '0;
    logic [31:0] cmd_key = '0, cmd_seq = '0, cmd_vec = '0;
    logic [CNT_W-1:0] cmd_count = '0;
    logic        cmd_ready, alloc_req, alloc_grant = 1'b0, alloc_fail = 1'b0;
    logic [CNT_W-1:0] alloc_count, rsp_count;
    logic [31:0] alloc_base = '0, msg_addr, rsp_seq, rsp_irq;
    logic        msg_valid, rsp_done, rsp_edge;
    logic [7:0]  rsp_status;
    logic [1:0]  rsp_type;

    int n_checks = 0, n_err = 0, msg_n = 0, grants = 0, wait_n = 0;
    logic [31:0] msg_log [32];
    logic        alloc_seen = 1'b0, fail_next = 1'b0, finished = 1'b0;
    logic [CNT_W-1:0] alloc_cnt_seen = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_vec_table #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .WIN_BASE(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_query(cmd_query), .cmd_func(cmd_func), .cmd_key(cmd_key),
        .cmd_count(cmd_count), .cmd_seq(cmd_seq), .cmd_vec(cmd_vec),
        .alloc_req(alloc_req), .alloc_count(alloc_count),
        .alloc_grant(alloc_grant), .alloc_fail(alloc_fail), .alloc_base(alloc_base),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .rsp_done(rsp_done),
        .rsp_status(rsp_status), .rsp_count(rsp_count), .rsp_seq(rsp_seq),
        .rsp_type(rsp_type), .rsp_irq(rsp_irq), .rsp_edge(rsp_edge)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    // Monitor: log message addresses and allocator requests.
    initial forever begin
        @(negedge clk);
        if (msg_valid && msg_n < 32) begin
            msg_log[msg_n] = msg_addr;
            msg_n++;
        end
        if (alloc_req) begin
            alloc_seen = 1'b1;
            alloc_cnt_seen = alloc_count;
        end
    end

    // Allocator model: answers on the second cycle of a request; slot s gets 64*(s+1).
    initial forever begin
        @(negedge clk);
        alloc_grant = 1'b0;
        alloc_fail  = 1'b0;
        if (alloc_req) begin
            wait_n++;
            if (wait_n == 2) begin
                wait_n = 0;
                if (fail_next) begin
                    alloc_fail = 1'b1;
                    fail_next  = 1'b0;
                end else begin
                    grants++;
                    alloc_grant = 1'b1;
                    alloc_base  = 32'(64 * grants);
                end
            end
        end else begin
            wait_n = 0;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic do_cmd(input logic q, input logic [3:0] f, input logic [31:0] k,
                          input logic [CNT_W-1:0] c, input logic [31:0] s, input logic [31:0] v);
        @(negedge clk);
        msg_n = 0;
        alloc_seen = 1'b0;
        cmd_query = q; cmd_func = f; cmd_key = k; cmd_count = c; cmd_seq = s; cmd_vec = v;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R1 busy after accept", cmd_ready, 1'b0);
        for (int t = 0; t < 200 && !rsp_done; t++) @(negedge clk);
    endtask

    task automatic expect_err(input string tag, input logic [7:0] st);
        check({tag, " status"}, rsp_status, st);
        check({tag, " count"}, rsp_count, 0);
        check({tag, " type"}, rsp_type, 0);
        check({tag, " no msgs"}, msg_n, 0);
    endtask

    task automatic enable(input string tag, input logic [3:0] f, input logic [31:0] k,
                          input logic [CNT_W-1:0] c, input logic [31:0] s,
                          input int slot, input logic fresh);
        int ty, n;
        do_cmd(1'b0, f, k, c, s, 0);
        ty = (f == 4) ? 2 : 1;
        n  = (ty == 2) ? int'(c) : 1;
        check({tag, " R3 status"}, rsp_status, 8'h00);
        check({tag, " R3 count"}, rsp_count, c);
        check({tag, " R3 seq"}, rsp_seq, s + 1);
        check({tag, " R2 type"}, rsp_type, ty);
        check({tag, " R6 alloc use"}, alloc_seen, fresh);
        if (fresh) check({tag, " R3 alloc count"}, alloc_cnt_seen, c);
        check({tag, " R9 msg count"}, msg_n, n);
        for (int i = 0; i < n && i < msg_n; i++)
            check({tag, " R9 R10 msg addr"}, msg_log[i],
                  WIN | (32'(slot) << 16) | ((ty == 2) ? (32'(i) << 2) : 32'h0));
    endtask

    task automatic query_ok(input string tag, input logic [31:0] k, input int slot, input int v);
        do_cmd(1'b1, 4'd0, k, 0, 0, 32'(v));
        check({tag, " R8 status"}, rsp_status, 8'h00);
        check({tag, " R8 irq"}, rsp_irq, 64 * (slot + 1) + v);
        check({tag, " R8 edge"}, rsp_edge, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset ready", cmd_ready, 1'b1);
        check("R1 reset done", rsp_done, 1'b0);
        check("R9 reset msg", msg_valid, 1'b0);
        check("R4 reset alloc", alloc_req, 1'b0);
        rst_n = 1'b1;

        // R2: every code other than 1, 3, 4 is a parameter error.
        for (int f = 0; f < 16; f++) begin
            if (f != 1 && f != 3 && f != 4) begin
                do_cmd(1'b0, 4'(f), 32'h100, 4'd2, 5, 0);
                expect_err("R2 bad func", 8'hFD);
                check("R2 no alloc", alloc_seen, 1'b0);
            end
        end
        @(negedge clk);
        check("R1 done one cycle", rsp_done, 1'b0);
        check("R1 fields held", rsp_status, 8'hFD);

        do_cmd(1'b1, 4'd0, 32'h100, 0, 0, 0);
        expect_err("R8 unknown query", 8'hFF);
        check("R8 unknown edge", rsp_edge, 1'b0);
        do_cmd(1'b0, 4'd1, 32'h100, 0, 0, 0);
        expect_err("R7 unknown release", 8'hFF);

        enable("dev100", 4'd4, 32'h100, 4'd3, 7, 0, 1'b1);

        fail_next = 1'b1;
        do_cmd(1'b0, 4'd1, 32'h200, 4'd2, 9, 0);
        expect_err("R4 alloc fail", 8'hFF);
        check("R4 alloc raised", alloc_seen, 1'b1);
        do_cmd(1'b1, 4'd0, 32'h200, 0, 0, 0);
        expect_err("R4 not stored", 8'hFF);

        enable("dev200", 4'd3, 32'h200, 4'd2, 11, 1, 1'b1);
        enable("R6 reuse", 4'd1, 32'h100, 4'd3, 20, 0, 1'b0);
        do_cmd(1'b0, 4'd4, 32'h100, 4'd4, 21, 0);
        expect_err("R6 count mismatch", 8'hFF);
        check("R6 no alloc", alloc_seen, 1'b0);

        for (int v = 0; v < 3; v++) query_ok("dev100", 32'h100, 0, v);
        query_ok("dev200", 32'h200, 1, 1);

        do_cmd(1'b0, 4'd1, 32'h100, 0, 30, 0);
        check("R7 release status", rsp_status, 8'h00);
        check("R7 release count", rsp_count, 0);
        query_ok("R7 kept", 32'h100, 0, 2);

        enable("dev300", 4'd1, 32'h300, 4'd1, 40, 2, 1'b1);
        enable("dev400", 4'd4, 32'h400, 4'd15, 50, 3, 1'b1);
        do_cmd(1'b0, 4'd4, 32'h500, 4'd2, 60, 0);
        expect_err("R5 table full", 8'hFF);
        check("R5 no alloc", alloc_seen, 1'b0);

        for (int s = 0; s < ENTRIES; s++)
            query_ok("R10 slot sweep", 32'h100 * 32'(s + 1), s, s + 5);

        summary();
    end
endmodule